// File: doc/BRIEF.md
# Floating-Point Operand Screen

This block inspects one operand before a floating-point unit acts on it and reports which exception events that operand causes. The operand can be a single-precision or double-precision bit pattern, or a signed 64-bit integer. An operation-class input says how the operand will be used: as an arithmetic source, as the source of a float-to-integer conversion, or as a long integer that will be converted to floating point.

The screen sorts the bit pattern into one of five classes: NaN, infinity, subnormal, zero or normal. It also separates quiet NaNs from signalling NaNs. For conversions it compares the magnitude against fixed limits. These limits are set by the precision of the conversion path, not by the width of the integer. Three outputs result. One is an invalid-operation event. One is an unimplemented-operation event. The third is an abort flag, which tells the pipeline to drop a long-to-float conversion.

All outputs are combinational. They depend only on the operand, the precision select and the class code. Carrying out the operation and recording the events in a status register are left to the surrounding unit.

Top module: `fpchk_operand_screen`

## Requirements
- R1: Arithmetic class (op_class_i = 0). A NaN has an all-ones exponent and a nonzero fraction. For single precision the exponent is bits 30:23 and the fraction is bits 22:0. For double precision the exponent is bits 62:52 and the fraction is bits 51:0. A NaN whose exponent is all ones and whose top fraction bit is set (bit 22 single, bit 51 double) is quiet and raises only ev_invalid_o. Any other NaN is signalling and raises only ev_unimpl_o.
- R2: Arithmetic class. A subnormal operand (exponent zero, fraction nonzero) raises ev_unimpl_o and not ev_invalid_o.
- R3: Arithmetic class. Infinities and normal values raise no event.
- R4: In the arithmetic and float-to-integer classes, a floating-point zero of either sign raises no event. In the long-to-float class, an integer zero raises no event.
- R5: Float-to-integer class (op_class_i = 1). Any NaN, quiet or signalling, raises ev_unimpl_o. So do an infinity and a subnormal. ev_invalid_o is never raised in this class.
- R6: Float-to-integer class, single precision. A normal value with magnitude at least 2^31 raises ev_unimpl_o. This covers +2^31 and -2^31. A smaller normal value raises nothing.
- R7: Float-to-integer class, double precision. A normal value with magnitude at least 2^53 raises ev_unimpl_o. A smaller normal value raises nothing.
- R8: Long-to-float class (op_class_i = 2). A signed 64-bit operand that is at least 2^55, or below -2^55, raises both ev_unimpl_o and abort_o. The value -2^55 itself raises nothing. The precision select has no effect in this class.
- R9: abort_o is low in every class other than long-to-float. It is also low for every in-range long operand.
- R10: With single precision selected, operand bits 63:32 have no effect on any output.
- R11: Class code 3 is reserved. It raises no event, whatever the operand is.
- R12: All outputs follow their inputs combinationally, in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 64 | Operand bits. Single precision uses bits 31:0. Double precision and long integers use all 64 bits. |
| is_double_i | input | 1 | 1 selects double precision, 0 selects single precision. Ignored in the long-to-float class. |
| op_class_i | input | 2 | 0 arithmetic, 1 float-to-integer, 2 long-to-float, 3 reserved |
| ev_invalid_o | output | 1 | Invalid-operation event |
| ev_unimpl_o | output | 1 | Unimplemented-operation event |
| abort_o | output | 1 | Drop the long-to-float conversion |

## Verification
Every result of this block is due in the same cycle its inputs are applied, because no register lies on any path. The bench applies each operand, precision and class on a falling clock edge. It then waits two nanoseconds, well before the next rising edge, and compares all three outputs against values worked out from the requirements. The stimuli sit on the class boundaries. These include the smallest quiet-NaN pattern, the largest in-range and smallest out-of-range conversion magnitudes, and the exact -2^55 edge. A boundary that slips by one exponent step or one integer therefore shows up in the check for that exact pattern.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;

   typedef enum logic [1:0] {
      OPC_ARITH = 2'd0,
      OPC_F2I   = 2'd1,
      OPC_L2F   = 2'd2,
      OPC_RSVD  = 2'd3
   } op_class_e;

   typedef struct packed {
      logic nan;
      logic qnan;
      logic inf;
      logic sub;
      logic zero;
      logic norm;
   } fp_class_t;

endpackage

// File: rtl/fpchk_classify.sv
module fpchk_classify
   import fpchk_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] bits_i,
   output fp_class_t             cls_o
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              exp_zero;
   logic              frac_zero;

   assign exp_f     = bits_i[EXP_W+FRAC_W-1:FRAC_W];
   assign frac_f    = bits_i[FRAC_W-1:0];
   assign exp_ones  = &exp_f;
   assign exp_zero  = ~|exp_f;
   assign frac_zero = ~|frac_f;

   always_comb begin
      cls_o.nan  = exp_ones && !frac_zero;
      cls_o.qnan = exp_ones && frac_f[FRAC_W-1];
      cls_o.inf  = exp_ones && frac_zero;
      cls_o.sub  = exp_zero && !frac_zero;
      cls_o.zero = exp_zero && frac_zero;
      cls_o.norm = !exp_ones && !exp_zero;
   end

   always_comb begin
      AST_ONE_CLASS: assert ($countones({cls_o.nan, cls_o.inf, cls_o.sub, cls_o.zero, cls_o.norm}) == 1)
         else $error("operand falls in other than exactly one class"); // R3
      AST_QNAN_IS_NAN: assert (!cls_o.qnan || cls_o.nan)
         else $error("quiet flag outside NaN class"); // R1
   end

endmodule

// File: rtl/fpchk_fp_range.sv
module fpchk_fp_range #(
   parameter int EXP_W     = 8,
   parameter int LIMIT_EXP = 31
) (
   input  logic [EXP_W-1:0] exp_i,
   output logic             too_big_o
);

   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] THRESH = EXP_W'(BIAS + LIMIT_EXP);

   if (BIAS + LIMIT_EXP >= (1 << EXP_W) - 1) begin : g_bad_limit
      $error("conversion limit exceeds exponent range");
   end

   assign too_big_o = (exp_i >= THRESH);

endmodule

// File: rtl/fpchk_long_range.sv
module fpchk_long_range #(
   parameter int INT_W     = 64,
   parameter int LIMIT_EXP = 55
) (
   input  logic [INT_W-1-LIMIT_EXP:0] upper_i,
   output logic                       out_of_range_o
);

   if (LIMIT_EXP < 1 || LIMIT_EXP >= INT_W - 1) begin : g_bad_limit
      $error("long conversion limit must leave a sign field");
   end

   assign out_of_range_o = !((&upper_i) || (~|upper_i));

endmodule

// File: rtl/fpchk_event_decode.sv
module fpchk_event_decode
   import fpchk_pkg::*;
(
   input  fp_class_t  cls_i,
   input  logic       fp_too_big_i,
   input  logic       long_oor_i,
   input  logic [1:0] op_class_i,
   output logic       ev_invalid_o,
   output logic       ev_unimpl_o,
   output logic       abort_o
);

   logic nonzero;
   assign nonzero = !cls_i.zero;

   always_comb begin
      ev_invalid_o = 1'b0;
      ev_unimpl_o  = 1'b0;
      abort_o      = 1'b0;
      case (op_class_i)
         OPC_ARITH: begin
            ev_invalid_o = nonzero && cls_i.qnan;
            ev_unimpl_o  = nonzero && ((cls_i.nan && !cls_i.qnan) || cls_i.sub);
         end
         OPC_F2I: begin
            ev_unimpl_o = nonzero && (cls_i.nan || cls_i.inf || cls_i.sub ||
                                      (cls_i.norm && fp_too_big_i));
         end
         OPC_L2F: begin
            ev_unimpl_o = long_oor_i;
            abort_o     = long_oor_i;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/fpchk_operand_screen.sv
module fpchk_operand_screen
   import fpchk_pkg::*;
#(
   parameter int OPND_W       = 64,
   parameter int SGL_EXP_W    = 8,
   parameter int SGL_FRAC_W   = 23,
   parameter int DBL_EXP_W    = 11,
   parameter int DBL_FRAC_W   = 52,
   parameter int SGL_CVT_LIM  = 31,
   parameter int DBL_CVT_LIM  = 53,
   parameter int LONG_CVT_LIM = 55
) (
   input  logic [OPND_W-1:0] operand_i,
   input  logic              is_double_i,
   input  logic [1:0]        op_class_i,
   output logic              ev_invalid_o,
   output logic              ev_unimpl_o,
   output logic              abort_o
);

   localparam int NUM_PREC = 2;

   if (DBL_EXP_W + DBL_FRAC_W + 1 > OPND_W) begin : g_bad_width
      $error("operand width too small for double format");
   end
   if (SGL_EXP_W + SGL_FRAC_W + 1 > DBL_EXP_W + DBL_FRAC_W + 1) begin : g_bad_order
      $error("single format wider than double format");
   end

   fp_class_t cls_w [NUM_PREC];
   logic      too_big_w [NUM_PREC];
   fp_class_t cls_sel;
   logic      too_big_sel;
   logic      long_oor;

   for (genvar p = 0; p < NUM_PREC; p++) begin : g_prec
      localparam int EW  = (p == 1) ? DBL_EXP_W   : SGL_EXP_W;
      localparam int FW  = (p == 1) ? DBL_FRAC_W  : SGL_FRAC_W;
      localparam int LIM = (p == 1) ? DBL_CVT_LIM : SGL_CVT_LIM;

      fpchk_classify #(
         .EXP_W  (EW),
         .FRAC_W (FW)
      ) classify_i (
         .bits_i (operand_i[EW+FW:0]),
         .cls_o  (cls_w[p])
      );

      fpchk_fp_range #(
         .EXP_W     (EW),
         .LIMIT_EXP (LIM)
      ) range_i (
         .exp_i     (operand_i[EW+FW-1:FW]),
         .too_big_o (too_big_w[p])
      );
   end

   assign cls_sel     = is_double_i ? cls_w[1]     : cls_w[0];
   assign too_big_sel = is_double_i ? too_big_w[1] : too_big_w[0];

   fpchk_long_range #(
      .INT_W     (OPND_W),
      .LIMIT_EXP (LONG_CVT_LIM)
   ) long_range_i (
      .upper_i        (operand_i[OPND_W-1:LONG_CVT_LIM]),
      .out_of_range_o (long_oor)
   );

   fpchk_event_decode decode_i (
      .cls_i        (cls_sel),
      .fp_too_big_i (too_big_sel),
      .long_oor_i   (long_oor),
      .op_class_i   (op_class_i),
      .ev_invalid_o (ev_invalid_o),
      .ev_unimpl_o  (ev_unimpl_o),
      .abort_o      (abort_o)
   );

   always_comb begin
      AST_EVENTS_EXCLUSIVE: assert (!(ev_invalid_o && ev_unimpl_o))
         else $error("invalid and unimplemented raised together"); // R1
      AST_ZERO_SILENT: assert (!(cls_sel.zero && op_class_i != OPC_L2F) || (!ev_invalid_o && !ev_unimpl_o))
         else $error("zero operand raised an event"); // R4
      AST_ABORT_ONLY_L2F: assert (!abort_o || (op_class_i == OPC_L2F && ev_unimpl_o))
         else $error("abort outside an out-of-range long conversion"); // R9
      AST_INVALID_ARITH_ONLY: assert (!ev_invalid_o || (op_class_i == OPC_ARITH && cls_sel.nan))
         else $error("invalid raised outside arithmetic NaN"); // R5
      AST_RSVD_SILENT: assert (op_class_i != OPC_RSVD || (!ev_invalid_o && !ev_unimpl_o && !abort_o))
         else $error("reserved class raised an event"); // R11
      AST_F2I_INF_UNIMPL: assert (!(op_class_i == OPC_F2I && cls_sel.inf) || ev_unimpl_o)
         else $error("infinite convert operand not flagged"); // R5
   end

endmodule

// File: tb/fpchk_operand_screen_tb.sv
module fpchk_operand_screen_tb_top;

   logic        clk;
   logic        rst_n;
   logic [63:0] operand;
   logic        is_double;
   logic [1:0]  op_class;
   logic        ev_invalid;
   logic        ev_unimpl;
   logic        abort_sig;

   int checks;
   int errors;
   bit done;

   fpchk_operand_screen dut_i (
      .operand_i    (operand),
      .is_double_i  (is_double),
      .op_class_i   (op_class),
      .ev_invalid_o (ev_invalid),
      .ev_unimpl_o  (ev_unimpl),
      .abort_o      (abort_sig)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   task automatic apply_check(input string req, input logic [63:0] opnd, input logic dbl,
                              input logic [1:0] cls, input logic e_inv, input logic e_unimp,
                              input logic e_abort);
      @(negedge clk);
      operand   = opnd;
      is_double = dbl;
      op_class  = cls;
      #2;
      checks++;
      if (ev_invalid !== e_inv || ev_unimpl !== e_unimp || abort_sig !== e_abort) begin
         errors++;
         $display("FAIL %s operand=%h dbl=%0b class=%0d actual inv/unimp/abort=%0b%0b%0b expected=%0b%0b%0b",
                  req, opnd, dbl, cls, ev_invalid, ev_unimpl, abort_sig, e_inv, e_unimp, e_abort);
      end
   endtask

   task automatic t_idle_state();
      apply_check("R4 idle", 64'h0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_arith_nan();
      apply_check("R1 sgl qnan", 64'h7FC00000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
      apply_check("R1 sgl snan", 64'h7F800001, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
      apply_check("R1 sgl snan high frac", 64'hFFBFFFFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
      apply_check("R1 dbl qnan", 64'h7FF8000000000000, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0);
      apply_check("R1 dbl snan", 64'h7FF0000000000001, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_arith_other();
      apply_check("R2 sgl sub", 64'h00000001, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
      apply_check("R2 dbl sub", 64'h800FFFFFFFFFFFFF, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0);
      apply_check("R3 sgl inf", 64'hFF800000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R3 dbl inf", 64'h7FF0000000000000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R3 sgl norm", 64'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R3 dbl norm", 64'h3FF0000000000000, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_zero();
      apply_check("R4 sgl -0 arith", 64'h80000000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R4 dbl -0 f2i", 64'h8000000000000000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R4 sgl +0 f2i", 64'h0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R4 long zero", 64'h0, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_f2i_special();
      apply_check("R5 qnan f2i", 64'h7FC00000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R5 snan f2i", 64'h7FF0000000000001, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R5 inf f2i", 64'h7F800000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R5 sub f2i", 64'h0000000000000001, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_f2i_range();
      apply_check("R6 sgl +2^31", 64'h4F000000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R6 sgl -2^31", 64'hCF000000, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R6 sgl below", 64'h4EFFFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R6 sgl neg below", 64'hCEFFFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R7 dbl +2^53", 64'h4340000000000000, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R7 dbl -2^53", 64'hC340000000000000, 1'b1, 2'd1, 1'b0, 1'b1, 1'b0);
      apply_check("R7 dbl below", 64'h433FFFFFFFFFFFFF, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R7 dbl 2^31 ok", 64'h41E0000000000000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_long();
      apply_check("R8 +2^55", 64'h0080000000000000, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1);
      apply_check("R8 below +2^55", 64'h007FFFFFFFFFFFFF, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0);
      apply_check("R8 -2^55", 64'hFF80000000000000, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0);
      apply_check("R8 below -2^55", 64'hFF7FFFFFFFFFFFFF, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1);
      apply_check("R8 most negative", 64'h8000000000000000, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1);
      apply_check("R8 nan pattern as long", 64'h7FF8000000000000, 1'b1, 2'd2, 1'b0, 1'b1, 1'b1);
   endtask

   task automatic t_abort_low();
      apply_check("R9 f2i oor no abort", 64'h0080000000000000, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0);
      apply_check("R9 arith big no abort", 64'h8000000000000000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_upper_ignored();
      apply_check("R10 upper ones norm", 64'hFFFFFFFF3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R10 upper junk snan", 64'h123456787F800001, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0);
      apply_check("R10 upper qnan dbl pattern", 64'h7FF8000000000000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_reserved();
      apply_check("R11 rsvd snan", 64'h7F800001, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0);
      apply_check("R11 rsvd long oor", 64'h8000000000000000, 1'b1, 2'd3, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_same_cycle();
      // R12: back-to-back operands, each checked within the cycle it is applied
      apply_check("R12 step a", 64'h7FC00000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0);
      apply_check("R12 step b", 64'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0);
      apply_check("R12 step c", 64'h0080000000000000, 1'b0, 2'd2, 1'b0, 1'b1, 1'b1);
   endtask

   initial begin
      checks    = 0;
      errors    = 0;
      done      = 1'b0;
      rst_n     = 1'b0;
      operand   = '0;
      is_double = 1'b0;
      op_class  = 2'd0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_idle_state();
      t_arith_nan();
      t_arith_other();
      t_zero();
      t_f2i_special();
      t_f2i_range();
      t_long();
      t_abort_low();
      t_upper_ignored();
      t_reserved();
      t_same_cycle();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule